// File: doc/BRIEF.md
# Processor status register unit

This block keeps the 16-bit processor status word of a CPU core. The word is built from three fields: a 3-bit interrupt level mask in the top bits, a 5-bit register bank pointer in the middle, and an 8-bit condition code byte at the bottom. The condition code byte holds the maskable-interrupt enable bit I, the stack select bit S, and the result flags T, N, Z, V and C.

The execution unit updates individual flags through per-bit strobes. Control code replaces the whole word at once, and the interrupt controller signals when an interrupt is accepted. Accepting an interrupt forces S to the system stack. The block drives a stack select output and an interrupt enable output. It can be read as a whole word or field by field. Level comparison, bank address arithmetic and the ALU are outside this block.

Top module: `proc_status_unit`

## Requirements
- R1: The word read on psw_o is {mask level in bits 15:13, bank pointer in bits 12:8, condition code byte in bits 7:0}. ilm_o, rp_o and ccr_o show the same fields on their own.
- R2: The condition code byte is ordered from bit 7 down to bit 0 as: unused, I, S, T, N, Z, V, C. Bit 7 always reads 0, and a write to it has no effect.
- R3: While rst_ni is low, and after it is released with no other input active, I reads 0, S reads 1, the mask level reads 0 and the bank pointer reads 0. In that state irq_en_o is 0 and use_ssp_o is 1. T, N, Z, V and C are loaded with a fixed value that is not specified.
- R4: When irq_ack_i is high at a clock edge, S reads 1 after that edge. This takes priority over any flag strobe or word write to S in the same cycle. All other bits follow their normal update.
- R5: use_ssp_o equals S. A value of 1 selects the system stack and 0 selects the user stack.
- R6: irq_en_o equals I. A value of 1 enables maskable interrupts and 0 masks them.
- R7: When wr_word_en_i is high at a clock edge, every field takes its value from wr_word_i after that edge, except bit 7.
- R8: flag_we_i[k] high at a clock edge loads flag_d_i[k] into condition code bit k, for k from 0 to 6. Bit positions are the same as in R2. Bits whose strobe is low keep their value, and the mask level and bank pointer do not change.
- R9: In a cycle with both a word write and flag strobes, the strobed bits take flag_d_i and the other bits take wr_word_i.
- R10: With no write, strobe or interrupt acceptance, the whole word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_word_en_i | input | 1 | Whole-word write enable |
| wr_word_i | input | 16 | Whole-word write data |
| flag_we_i | input | 7 | Per-bit strobes for condition code bits 6..0 |
| flag_d_i | input | 7 | Per-bit data for condition code bits 6..0 |
| irq_ack_i | input | 1 | Interrupt accepted this cycle |
| psw_o | output | 16 | Full status word |
| ilm_o | output | 3 | Interrupt level mask field |
| rp_o | output | 5 | Register bank pointer field |
| ccr_o | output | 8 | Condition code byte |
| use_ssp_o | output | 1 | 1 selects the system stack, 0 selects the user stack |
| irq_en_o | output | 1 | Maskable interrupt enable |

## Verification
Whole-word writes use all-ones, alternating and all-zero patterns. These show that each field lands in its own bit range and that bit 7 stays 0. Single-flag and two-flag strobes show that unselected bits hold and that the upper fields do not move. Cycles that combine inputs separate the priority rules: a strobe together with a word write, and a strobe clearing S together with an interrupt acceptance. Idle cycles after a nonzero word show that the value holds.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int ILM_W  = 3;
  localparam int RP_W   = 5;
  localparam int CCR_W  = 8;
  localparam int PSW_W  = ILM_W + RP_W + CCR_W;
  localparam int FLAG_N = CCR_W - 1;  // bit 7 unused
  localparam int CCR_C  = 0;
  localparam int CCR_V  = 1;
  localparam int CCR_Z  = 2;
  localparam int CCR_N  = 3;
  localparam int CCR_T  = 4;
  localparam int CCR_S  = 5;
  localparam int CCR_I  = 6;
  localparam int RP_LSB  = CCR_W;
  localparam int ILM_LSB = CCR_W + RP_W;
endpackage

// File: rtl/psw_flag_bit.sv
module psw_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_we_i,
  input  logic word_d_i,
  input  logic upd_we_i,
  input  logic upd_d_i,
  input  logic force_set_i,
  output logic q_o
);
  // priority: forced set > strobe > word write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= RST_VAL;
    else if (force_set_i) q_o <= 1'b1;
    else if (upd_we_i)    q_o <= upd_d_i;
    else if (word_we_i)   q_o <= word_d_i;
  end
endmodule

// File: rtl/psw_hi_reg.sv
module psw_hi_reg #(
  parameter int ILM_W = 3,
  parameter int RP_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ILM_W-1:0] ilm_d_i,
  input  logic [RP_W-1:0]  rp_d_i,
  output logic [ILM_W-1:0] ilm_q_o,
  output logic [RP_W-1:0]  rp_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilm_q_o <= '0;
      rp_q_o  <= '0;
    end else if (we_i) begin
      ilm_q_o <= ilm_d_i;
      rp_q_o  <= rp_d_i;
    end
  end
endmodule

// File: rtl/psw_pack.sv
module psw_pack
  import ps_pkg::*;
(
  input  logic [ILM_W-1:0]  ilm_i,
  input  logic [RP_W-1:0]   rp_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic              use_ssp_o,
  output logic              irq_en_o
);
  always_comb begin
    ccr_o     = {1'b0, flags_i};
    psw_o     = {ilm_i, rp_i, ccr_o};
    use_ssp_o = flags_i[CCR_S];
    irq_en_o  = flags_i[CCR_I];
  end
endmodule

// File: rtl/proc_status_unit.sv
module proc_status_unit
  import ps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_word_en_i,
  input  logic [PSW_W-1:0]  wr_word_i,
  input  logic [FLAG_N-1:0] flag_we_i,
  input  logic [FLAG_N-1:0] flag_d_i,
  input  logic              irq_ack_i,
  output logic [PSW_W-1:0]  psw_o,
  output logic [ILM_W-1:0]  ilm_o,
  output logic [RP_W-1:0]   rp_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              use_ssp_o,
  output logic              irq_en_o
);
  logic [FLAG_N-1:0] flags_q;
  logic              unused_bit7;

  assign unused_bit7 = wr_word_i[CCR_W-1];

  psw_hi_reg #(.ILM_W(ILM_W), .RP_W(RP_W)) u_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_word_en_i),
    .ilm_d_i (wr_word_i[ILM_LSB +: ILM_W]),
    .rp_d_i  (wr_word_i[RP_LSB +: RP_W]),
    .ilm_q_o (ilm_o),
    .rp_q_o  (rp_o)
  );

  for (genvar k = 0; k < FLAG_N; k++) begin : g_flag
    localparam logic RV = (k == CCR_S) ? 1'b1 : 1'b0;
    logic force_set;
    if (k == CCR_S) begin : g_s
      assign force_set = irq_ack_i;
    end else begin : g_n
      assign force_set = 1'b0;
    end
    psw_flag_bit #(.RST_VAL(RV)) u_bit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .word_we_i   (wr_word_en_i),
      .word_d_i    (wr_word_i[k]),
      .upd_we_i    (flag_we_i[k]),
      .upd_d_i     (flag_d_i[k]),
      .force_set_i (force_set),
      .q_o         (flags_q[k])
    );
  end

  psw_pack u_pack (
    .ilm_i     (ilm_o),
    .rp_i      (rp_o),
    .flags_i   (flags_q),
    .ccr_o     (ccr_o),
    .psw_o     (psw_o),
    .use_ssp_o (use_ssp_o),
    .irq_en_o  (irq_en_o)
  );
endmodule

// File: rtl/proc_status_unit_chk.sv
module proc_status_unit_chk
  import ps_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_word_en_i,
  input logic [PSW_W-1:0]  wr_word_i,
  input logic [FLAG_N-1:0] flag_we_i,
  input logic [FLAG_N-1:0] flag_d_i,
  input logic              irq_ack_i,
  input logic [PSW_W-1:0]  psw_o,
  input logic [ILM_W-1:0]  ilm_o,
  input logic [RP_W-1:0]   rp_o,
  input logic [CCR_W-1:0]  ccr_o,
  input logic              use_ssp_o,
  input logic              irq_en_o
);
  a_r4_irq_sets_s: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> (ccr_o[CCR_S] && use_ssp_o));

  a_r7_word_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word_en_i && flag_we_i == '0 && !irq_ack_i) |=>
      psw_o == ($past(wr_word_i) & ~(PSW_W'(1) << (CCR_W-1))));

  a_r8_carry_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i[CCR_C] |=> ccr_o[CCR_C] == $past(flag_d_i[CCR_C]));

  a_r8_hi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_word_en_i |=> $stable({ilm_o, rp_o}));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_word_en_i && flag_we_i == '0 && !irq_ack_i) |=> $stable(psw_o));

  a_r2_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_word_en_i |=> !psw_o[CCR_W-1]);
endmodule

bind proc_status_unit proc_status_unit_chk u_chk (.*);

// File: tb/proc_status_unit_test.sv
module proc_status_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_word_en_i = 1'b0;
  logic [15:0] wr_word_i = '0;
  logic [6:0]  flag_we_i = '0;
  logic [6:0]  flag_d_i = '0;
  logic        irq_ack_i = 1'b0;
  logic [15:0] psw_o;
  logic [2:0]  ilm_o;
  logic [4:0]  rp_o;
  logic [7:0]  ccr_o;
  logic        use_ssp_o;
  logic        irq_en_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  proc_status_unit uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_word_en_i = 1'b0; flag_we_i = '0; irq_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #20;
    chk("R3 reset psw masked", psw_o & 16'hFFE0, 16'h0020);
    chk("R3 reset use_ssp", {15'd0, use_ssp_o}, 16'd1);
    chk("R3 reset irq_en", {15'd0, irq_en_o}, 16'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    step();
    chk("R3 after release psw masked", psw_o & 16'hFFE0, 16'h0020);
  endtask

  task automatic t_word();
    wr_word_en_i = 1'b1; wr_word_i = 16'hFFFF; step();
    chk("R7 word all ones", psw_o, 16'hFF7F);
    chk("R2 bit7 ignores write", {15'd0, ccr_o[7]}, 16'd0);
    chk("R1 ilm field", {13'd0, ilm_o}, 16'h7);
    chk("R6 irq_en set", {15'd0, irq_en_o}, 16'd1);
    wr_word_en_i = 1'b1; wr_word_i = 16'hA5A5; step();
    chk("R7 word A5A5", psw_o, 16'hA525);
    chk("R1 ilm A5A5", {13'd0, ilm_o}, 16'h5);
    chk("R1 rp A5A5", {11'd0, rp_o}, 16'h05);
    chk("R1 ccr A5A5", {8'd0, ccr_o}, 16'h25);
    wr_word_en_i = 1'b1; wr_word_i = 16'h0000; step();
    chk("R7 word zero", psw_o, 16'h0000);
    chk("R5 user stack", {15'd0, use_ssp_o}, 16'd0);
    chk("R6 irq masked", {15'd0, irq_en_o}, 16'd0);
  endtask

  task automatic t_strobe();
    wr_word_en_i = 1'b1; wr_word_i = 16'h6A40; step();
    flag_we_i = 7'b0000001; flag_d_i = 7'b1111111; step();
    chk("R8 carry only", psw_o, 16'h6A41);
    flag_we_i = 7'b0001100; flag_d_i = 7'b0000100; step();
    chk("R8 N clear Z set", psw_o, 16'h6A45);
    flag_we_i = 7'b0100000; flag_d_i = 7'b0100000; step();
    chk("R5 S strobe selects system", {15'd0, use_ssp_o}, 16'd1);
    chk("R8 S strobe word", psw_o, 16'h6A65);
  endtask

  task automatic t_irq();
    wr_word_en_i = 1'b1; wr_word_i = 16'h1F5A; step();
    chk("R7 S cleared first", {15'd0, use_ssp_o}, 16'd0);
    irq_ack_i = 1'b1; step();
    chk("R4 irq sets S", psw_o, 16'h1F7A);
    wr_word_en_i = 1'b1; wr_word_i = 16'h0040; step();
    irq_ack_i = 1'b1; flag_we_i = 7'b0100001; flag_d_i = 7'b0000001; step();
    chk("R4 irq beats strobe", psw_o, 16'h0061);
    irq_ack_i = 1'b1; wr_word_en_i = 1'b1; wr_word_i = 16'h8000; step();
    chk("R4 irq beats word write", psw_o, 16'h8020);
  endtask

  task automatic t_mix();
    wr_word_en_i = 1'b1; wr_word_i = 16'h3C0F;
    flag_we_i = 7'b1000011; flag_d_i = 7'b1000000; step();
    chk("R9 strobe over word", psw_o, 16'h3C4C);
  endtask

  task automatic t_hold();
    repeat (3) step();
    chk("R10 idle hold", psw_o, 16'h3C4C);
    flag_we_i = '0; flag_d_i = 7'b1111111; wr_word_i = 16'hFFFF; step();
    chk("R10 data without enables", psw_o, 16'h3C4C);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_word();
        t_strobe();
        t_irq();
        t_mix();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule